// File: doc/BRIEF.md
# Multi-Bank Scratchpad Crossbar

This block joins a set of requesters to several independent single-ported scratchpad banks and to one external-memory port. The requesters are a configurable number of processor cores followed by four hardware assist units. Each requester has a valid/ready request channel that carries a word address, a write enable and 32-bit write data. It also has a return channel that gives read data, a write-acknowledge pulse and a decode-error pulse.

Every target has its own round-robin arbiter, which accepts at most one transaction per cycle. A request is arbitrated and crosses the switch in the cycle it is presented. The bank access happens at the next clock edge, and the result is on the requester's return channel in the following cycle. A requester that loses arbitration sees `req_ready` low and holds its request until it is granted. Only cores may use the external port. A core with an external read in flight gets no further grants until that read data returns, so its return channel never carries two results in one cycle.

Top module: `spm_xbar`

## Requirements
- R1: Address bit 15 low selects a scratchpad bank. Bits [1:0] pick the bank, bits [9:2] pick the word inside it, and bits [14:10] are ignored, so an address and the same address plus 1024 name the same word. A read returns the last value written to that word.
- R2: A granted bank read drives `rsp_valid` with the word on the requester's channel in the cycle after the grant. A granted bank write pulses `wr_ack` in the cycle after the grant and returns no data.
- R3: Each target grants at most one requester per cycle, and `req_ready` is high only while `req_valid` is high.
- R4: Arbitration is round robin over requester indices 0..9 (cores 0..5, assists 6..9). After a grant to index k, the search restarts at k+1 and wraps around. A requester holding its request to a bank waits at most 9 cycles.
- R5: A core request with address bit 15 high appears on the external port with `ext_tag` equal to the core index and the core's address, write enable and data. While `ext_ready` is low nothing is accepted.
- R6: An external write pulses `wr_ack` one cycle after acceptance. External read data on `ext_rvalid` is shown on the `rsp_valid`/`rsp_data` channel of the requester named by `ext_rtag` in that same cycle.
- R7: A core with an accepted external read gets no grant on any target until that read's data has returned.
- R8: An assist request with address bit 15 high is accepted in the same cycle, never reaches the external port, and pulses `dec_err` on that assist's channel one cycle later. It produces no other response.
- R9: Under reset all return pulses and `ext_valid` are low. After reset each arbiter gives requester 0 first priority.
- R10: Requests to different banks in the same cycle are all granted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N | Request present, one bit per requester |
| req_ready | output | N | Request accepted this cycle |
| req_we | input | N | Request is a write |
| req_addr | input | N x 16 | Word address per requester |
| req_wdata | input | N x 32 | Write data per requester |
| rsp_valid | output | N | Read data valid on the requester's channel |
| rsp_data | output | N x 32 | Read data per requester |
| wr_ack | output | N | Write completed pulse |
| dec_err | output | N | Rejected-address pulse |
| ext_valid | output | 1 | External request present |
| ext_ready | input | 1 | External port accepts this cycle |
| ext_we | output | 1 | External request is a write |
| ext_addr | output | 16 | External request address |
| ext_wdata | output | 32 | External write data |
| ext_tag | output | 4 | Index of the requesting core |
| ext_rvalid | input | 1 | External read data valid |
| ext_rdata | input | 32 | External read data |
| ext_rtag | input | 4 | Core that the external read data belongs to |

## Verification
The bound checker watches the per-cycle rules on every clock: one grant per bank, ready only with valid, fixed bank read and write latency, blocking during an outstanding external read, rejection of assist traffic to the external port, and a cycle counter that bounds how long any stalled bank request waits. The bench scenarios cover what these rules cannot show on their own. These are the exact rotation of grant order across several contention sets (including wrap-around), address aliasing and data integrity against a reference model, routing of external reads to the tagged core, and stalls while the external port is not ready.

// File: rtl/spm_xbar.sv
`timescale 1ns/1ps
module spm_xbar #(
  parameter int NCORE      = 6,
  parameter int NASSIST    = 4,
  parameter int NBANK      = 4,
  parameter int BANK_WORDS = 256,
  parameter int AW         = 16,
  parameter int DW         = 32,
  localparam int N    = NCORE + NASSIST,
  localparam int IDW  = $clog2(N),
  localparam int BSEL = $clog2(NBANK),
  localparam int IW   = $clog2(BANK_WORDS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N-1:0]           req_valid,
  output logic [N-1:0]           req_ready,
  input  logic [N-1:0]           req_we,
  input  logic [N-1:0][AW-1:0]   req_addr,
  input  logic [N-1:0][DW-1:0]   req_wdata,
  output logic [N-1:0]           rsp_valid,
  output logic [N-1:0][DW-1:0]   rsp_data,
  output logic [N-1:0]           wr_ack,
  output logic [N-1:0]           dec_err,
  output logic                   ext_valid,
  input  logic                   ext_ready,
  output logic                   ext_we,
  output logic [AW-1:0]          ext_addr,
  output logic [DW-1:0]          ext_wdata,
  output logic [IDW-1:0]         ext_tag,
  input  logic                   ext_rvalid,
  input  logic [DW-1:0]          ext_rdata,
  input  logic [IDW-1:0]         ext_rtag
);
  localparam int T  = NBANK + 1;
  localparam int XT = NBANK;

  logic [N-1:0]          pend, bad;
  logic [T-1:0][N-1:0]   want, gnt;
  logic [T-1:0][IDW-1:0] ptr, win;
  logic [T-1:0]          hit, fire;

  logic [NBANK-1:0]           bv, bwe;
  logic [NBANK-1:0][IDW-1:0]  bid;
  logic [NBANK-1:0][DW-1:0]   brd;
  logic                       ewa;
  logic [IDW-1:0]             ewid;

  always_comb begin
    want = '0;
    for (int r = 0; r < N; r++) begin
      bad[r] = req_valid[r] && req_addr[r][AW-1] && (r >= NCORE);
      if (req_valid[r] && !pend[r] && !bad[r]) begin
        if (req_addr[r][AW-1]) want[XT][r] = 1'b1;
        else                   want[int'(req_addr[r][BSEL-1:0])][r] = 1'b1;
      end
    end
  end

  always_comb begin
    int k;
    gnt = '0;
    hit = '0;
    win = '0;
    for (int t = 0; t < T; t++) begin
      for (int i = 1; i <= N; i++) begin
        k = (int'(ptr[t]) + i) % N;
        if (!hit[t] && want[t][k]) begin
          hit[t]    = 1'b1;
          win[t]    = IDW'(k);
          gnt[t][k] = 1'b1;
        end
      end
      fire[t] = hit[t] && ((t != XT) || ext_ready);
    end
  end

  always_comb begin
    for (int r = 0; r < N; r++) begin
      req_ready[r] = bad[r];
      for (int t = 0; t < T; t++)
        if (fire[t] && gnt[t][r]) req_ready[r] = 1'b1;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DW-1:0] mem [BANK_WORDS];
    logic [DW-1:0] rd_q;
    logic [IW-1:0] widx;
    assign widx   = req_addr[win[b]][BSEL +: IW];
    assign brd[b] = rd_q;
    always_ff @(posedge clk) begin
      if (fire[b]) begin
        if (req_we[win[b]]) mem[widx] <= req_wdata[win[b]];
        else                rd_q      <= mem[widx];
      end
    end
  end

  assign ext_valid = hit[XT];
  assign ext_tag   = win[XT];
  assign ext_we    = req_we[win[XT]];
  assign ext_addr  = req_addr[win[XT]];
  assign ext_wdata = req_wdata[win[XT]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bv      <= '0;
      bwe     <= '0;
      bid     <= '0;
      ewa     <= 1'b0;
      ewid    <= '0;
      pend    <= '0;
      dec_err <= '0;
      for (int t = 0; t < T; t++) ptr[t] <= IDW'(N-1);
    end else begin
      dec_err <= bad;
      ewa     <= fire[XT] && ext_we;
      ewid    <= win[XT];
      for (int b = 0; b < NBANK; b++) begin
        bv[b]  <= fire[b];
        bwe[b] <= req_we[win[b]];
        bid[b] <= win[b];
      end
      for (int t = 0; t < T; t++)
        if (fire[t]) ptr[t] <= win[t];
      for (int r = 0; r < N; r++) begin
        if (ext_rvalid && int'(ext_rtag) == r) pend[r] <= 1'b0;
        if (fire[XT] && !ext_we && int'(win[XT]) == r) pend[r] <= 1'b1;
      end
    end
  end

  always_comb begin
    rsp_valid = '0;
    rsp_data  = '0;
    wr_ack    = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (bv[b]) begin
        if (bwe[b]) wr_ack[bid[b]] = 1'b1;
        else begin
          rsp_valid[bid[b]] = 1'b1;
          rsp_data[bid[b]]  = brd[b];
        end
      end
    end
    if (ewa) wr_ack[ewid] = 1'b1;
    if (ext_rvalid && int'(ext_rtag) < N) begin
      rsp_valid[ext_rtag] = 1'b1;
      rsp_data[ext_rtag]  = ext_rdata;
    end
  end
endmodule

// File: rtl/spm_xbar_chk.sv
`timescale 1ns/1ps
module spm_xbar_chk #(
  parameter int NCORE   = 6,
  parameter int NASSIST = 4,
  parameter int NBANK   = 4,
  parameter int AW      = 16,
  localparam int N    = NCORE + NASSIST,
  localparam int IDW  = $clog2(N),
  localparam int BSEL = $clog2(NBANK)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         req_valid,
  input logic [N-1:0]         req_ready,
  input logic [N-1:0]         req_we,
  input logic [N-1:0][AW-1:0] req_addr,
  input logic [N-1:0]         rsp_valid,
  input logic [N-1:0]         wr_ack,
  input logic [N-1:0]         dec_err,
  input logic                 ext_valid,
  input logic [IDW-1:0]       ext_tag,
  input logic [N-1:0]         pend
);
  logic [NBANK-1:0][N-1:0] take;
  logic [N-1:0][IDW:0]     wait_c;

  always_comb begin
    take = '0;
    for (int r = 0; r < N; r++)
      if (req_valid[r] && req_ready[r] && !req_addr[r][AW-1])
        take[int'(req_addr[r][BSEL-1:0])][r] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_c <= '0;
    else
      for (int r = 0; r < N; r++)
        wait_c[r] <= (req_valid[r] && !req_ready[r] && !req_addr[r][AW-1] && !pend[r])
                     ? wait_c[r] + 1'b1 : '0;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_b
    AST_ONE_GRANT_PER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(take[b]) <= 1); // R3
  end

  for (genvar r = 0; r < N; r++) begin : g_r
    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[r] |-> req_valid[r]); // R3
    AST_BANK_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[r] && req_ready[r] && !req_addr[r][AW-1] && !req_we[r]) |=> rsp_valid[r]); // R2
    AST_BANK_WRITE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[r] && req_ready[r] && !req_addr[r][AW-1] && req_we[r]) |=> wr_ack[r]); // R2
    AST_PENDING_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      pend[r] |-> !req_ready[r]); // R7
    AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      wait_c[r] < (IDW+1)'(N)); // R4
  end

  for (genvar r = NCORE; r < N; r++) begin : g_a
    AST_ASSIST_EXT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[r] && req_addr[r][AW-1]) |-> req_ready[r]); // R8
    AST_ASSIST_EXT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[r] && req_addr[r][AW-1]) |=> dec_err[r]); // R8
  end

  AST_EXT_CORES_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> (int'(ext_tag) < NCORE)); // R8
endmodule

bind spm_xbar spm_xbar_chk #(.NCORE(NCORE), .NASSIST(NASSIST), .NBANK(NBANK), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .wr_ack(wr_ack), .dec_err(dec_err),
  .ext_valid(ext_valid), .ext_tag(ext_tag), .pend(pend));

// File: tb/sim_spm_xbar.sv
`timescale 1ns/1ps
module sim_spm_xbar;
  localparam int NCORE = 6, NASSIST = 4, NBANK = 4, BW = 256;
  localparam int N = NCORE + NASSIST;
  localparam logic [1:0] K_RD = 2'd0, K_WA = 2'd1, K_ER = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req_valid = '0, req_ready, req_we = '0;
  logic [N-1:0][15:0] req_addr = '0;
  logic [N-1:0][31:0] req_wdata = '0;
  logic [N-1:0] rsp_valid, wr_ack, dec_err;
  logic [N-1:0][31:0] rsp_data;
  logic ext_valid, ext_we;
  logic ext_ready = 1'b1, ext_rvalid = 1'b0;
  logic [15:0] ext_addr;
  logic [31:0] ext_wdata, ext_rdata = '0;
  logic [3:0] ext_tag, ext_rtag = '0;

  spm_xbar u0 (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, rv_cyc = -1;
  bit done = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string rq, input string msg,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, msg, act, exp);
    end
  endtask

  // scoreboard: {req4, cycle32, kind2, data32}
  logic [69:0] expq [N][$];
  logic [31:0] model [NBANK*BW];
  bit extout [N];

  task automatic push(input int r, input int rq, input int c, input logic [1:0] k, input logic [31:0] d);
    expq[r].push_back({4'(rq), 32'(c), k, d});
  endtask

  always @(negedge clk) if (rst_n) begin
    for (int r = 0; r < N; r++) begin
      logic [1:0] k;
      logic [69:0] it;
      string rq;
      bit seen;
      seen = 1'b1;
      k = K_RD;
      if (rsp_valid[r]) k = K_RD;
      else if (wr_ack[r]) k = K_WA;
      else if (dec_err[r]) k = K_ER;
      else seen = 1'b0;
      if (seen) begin
        if (expq[r].size() == 0) chk(1'b0, "R2", "unexpected response kind", 32'(k), 32'hFFFF);
        else begin
          it = expq[r].pop_front();
          rq = $sformatf("R%0d", it[69:66]);
          chk(it[33:32] == k, rq, $sformatf("response kind on requester %0d", r), 32'(k), 32'(it[33:32]));
          if (k == K_RD) chk(rsp_data[r] == it[31:0], rq, $sformatf("read data on requester %0d", r), rsp_data[r], it[31:0]);
          if (it[65:34] != 0) chk(int'(it[65:34]) == cyc, rq, "response cycle", 32'(cyc), it[65:34]);
          else begin extout[r] = 1'b0; rv_cyc = cyc; end
        end
      end
    end
  end

  // external memory model
  logic ext_en = 1'b1;
  bit busy = 0;
  int ecnt = 0;
  logic [3:0] etag;
  logic [31:0] edat;
  always @(negedge clk) if (rst_n && ext_valid && ext_ready && !ext_we) begin
    busy = 1; ecnt = 2; etag = ext_tag; edat = {16'hE0E0, ext_addr};
  end
  always @(posedge clk) begin
    #2;
    ext_rvalid = 1'b0;
    if (ecnt > 0) begin
      ecnt--;
      if (ecnt == 0) begin ext_rvalid = 1'b1; ext_rdata = edat; ext_rtag = etag; busy = 0; end
    end
    ext_ready = ext_en && !busy;
  end

  // driver
  bit bv [N], bwe [N];
  logic [15:0] baddr [N];
  logic [31:0] bdat [N];
  int acc_it [N], acc_cyc [N];
  int gorder [$];
  int iters;

  function automatic bit any_pending();
    for (int r = 0; r < N; r++) if (bv[r]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic accept(input int r, input int it);
    int key;
    acc_it[r] = it; acc_cyc[r] = cyc; gorder.push_back(r);
    chk(!extout[r], "R7", "grant while external read outstanding", 32'(r), 32'hFFFF);
    if (baddr[r][15]) begin
      if (r >= NCORE) begin
        chk(!ext_valid, "R8", "assist request reached external port", 32'(ext_valid), 0);
        push(r, 8, cyc + 1, K_ER, 0);
      end else begin
        chk(ext_valid && ext_tag == 4'(r) && ext_addr == baddr[r] && ext_we == bwe[r] &&
            (!bwe[r] || ext_wdata == bdat[r]), "R5", "external port fields",
            {12'd0, ext_tag, ext_addr}, {12'd0, 4'(r), baddr[r]});
        if (bwe[r]) push(r, 6, cyc + 1, K_WA, 0);
        else begin push(r, 6, 0, K_RD, {16'hE0E0, baddr[r]}); extout[r] = 1'b1; end
      end
    end else begin
      key = int'(baddr[r][1:0]) * BW + int'(baddr[r][9:2]);
      if (bwe[r]) begin model[key] = bdat[r]; push(r, 2, cyc + 1, K_WA, 0); end
      else push(r, 1, cyc + 1, K_RD, model[key]);
    end
  endtask

  task automatic run_batch(input int maxit);
    iters = 0;
    gorder.delete();
    while (any_pending() && iters < maxit) begin
      @(posedge clk); #2;
      for (int r = 0; r < N; r++) begin
        req_valid[r] = bv[r]; req_we[r] = bwe[r]; req_addr[r] = baddr[r]; req_wdata[r] = bdat[r];
      end
      @(negedge clk);
      iters++;
      for (int r = 0; r < N; r++)
        if (bv[r] && req_ready[r]) begin accept(r, iters); bv[r] = 1'b0; end
    end
    @(posedge clk); #2;
    req_valid = '0;
  endtask

  task automatic one(input int r, input bit we, input logic [15:0] a, input logic [31:0] d);
    bv[r] = 1'b1; bwe[r] = we; baddr[r] = a; bdat[r] = d;
    run_batch(50);
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
    for (int r = 0; r < N; r++)
      chk(expq[r].size() == 0, "R2", $sformatf("missing response on requester %0d", r), expq[r].size(), 0);
  endtask

  task automatic order_chk(input int exp [$], input string rq);
    chk(gorder.size() == exp.size(), rq, "grant count", gorder.size(), exp.size());
    for (int i = 0; i < exp.size() && i < gorder.size(); i++)
      chk(gorder[i] == exp[i], rq, $sformatf("grant order slot %0d", i), gorder[i], exp[i]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R2", "watchdog expired", 32'(cyc), 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(rsp_valid == 0 && wr_ack == 0 && dec_err == 0, "R9", "return pulses in reset",
        {rsp_valid, wr_ack, dec_err}, 0);
    chk(!ext_valid && req_ready == 0, "R9", "ext_valid / ready in reset", {ext_valid, req_ready}, 0);
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 0 && wr_ack == 0, "R9", "idle after reset", {rsp_valid, wr_ack}, 0);

    // R4 + R9: all requesters on bank 0, priority starts at 0
    for (int r = 0; r < N; r++) begin bv[r] = 1; bwe[r] = 1; baddr[r] = 16'(r * 4); bdat[r] = 32'(100 + r); end
    run_batch(50);
    order_chk('{0, 1, 2, 3, 4, 5, 6, 7, 8, 9}, "R4");
    chk(iters == N, "R4", "cycles to serve full contention", iters, N);
    drain();

    // R4: wrap-around of the pointer
    foreach (bv[r]) bv[r] = 0;
    bv[2] = 1; bv[5] = 1; bv[7] = 1;
    foreach (bwe[r]) begin bwe[r] = 0; baddr[r] = 16'(r * 4); end
    run_batch(50);
    order_chk('{2, 5, 7}, "R4");
    bv[1] = 1; bv[5] = 1; bv[8] = 1;
    run_batch(50);
    order_chk('{8, 1, 5}, "R4");
    drain();

    // R1: read back and aliasing
    for (int r = 0; r < N; r++) one(1, 0, 16'(r * 4), 0);
    one(2, 1, 16'd21, 32'hCAFE_0021);
    one(7, 0, 16'd21 + 16'd1024, 0);
    one(3, 1, 16'd22 + 16'd2048, 32'hBEEF_0022);
    one(9, 0, 16'd22, 0);
    drain();

    // R10: distinct banks in one cycle
    for (int r = 0; r < 4; r++) begin bv[r] = 1; bwe[r] = 1; baddr[r] = 16'(40 + r); bdat[r] = 32'h5A00 + 32'(r); end
    run_batch(50);
    chk(iters == 1, "R10", "four banks written in one cycle", iters, 1);
    for (int r = 4; r < 8; r++) begin bv[r] = 1; bwe[r] = 0; baddr[r] = 16'(36 + r); end
    run_batch(50);
    chk(iters == 1, "R10", "four banks read in one cycle", iters, 1);
    drain();

    // R5 / R6: external write and read
    one(3, 1, 16'h8010, 32'h1234_5678);
    one(0, 0, 16'h8123, 0);
    drain();
    chk(!extout[0], "R6", "external read returned to core 0", 32'(extout[0]), 0);

    // R7: blocking while an external read is in flight
    one(4, 0, 16'h8200, 0);
    one(4, 0, 16'd4, 0);
    chk(acc_cyc[4] == rv_cyc + 1, "R7", "bank grant cycle after external return", acc_cyc[4], rv_cyc + 1);
    drain();

    // R5: external port not ready
    ext_en = 1'b0;
    @(posedge clk); @(posedge clk);
    bv[2] = 1; bwe[2] = 0; baddr[2] = 16'h8044;
    run_batch(5);
    chk(gorder.size() == 0, "R5", "accepted while ext_ready low", gorder.size(), 0);
    ext_en = 1'b1;
    run_batch(50);
    chk(gorder.size() == 1, "R5", "accepted after ext_ready", gorder.size(), 1);
    drain();

    // R8: assist to external port
    one(6, 1, 16'h8008, 32'h7777);
    chk(iters == 1, "R8", "assist external request taken at once", iters, 1);
    one(9, 0, 16'hC000, 0);
    drain();

    // random traffic with wait bound
    for (int k = 0; k < 64; k++) one(k % N, 1, 16'(k), 32'(k * 7 + 3));
    drain();
    for (int b = 0; b < 150; b++) begin
      for (int r = 0; r < N; r++) begin
        bv[r] = 1'($urandom % 2); bwe[r] = 1'($urandom % 2);
        baddr[r] = 16'($urandom % 64); bdat[r] = $urandom;
        acc_it[r] = 0;
      end
      run_batch(50);
      for (int r = 0; r < N; r++)
        if (acc_it[r] > N) chk(1'b0, "R4", $sformatf("wait of requester %0d", r), acc_it[r], N);
      chk(iters <= N, "R4", "random batch length", iters, N);
    end
    drain();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule